// File: doc/BRIEF.md
# Filter Output Rounding Shift and Offset Stage

This block post-processes the wide results that leave a decimation filter, one channel at a time. Each incoming sample carries a channel index. That index selects two per-channel settings: a right-shift amount and a signed offset. The sample is first scaled down by the selected shift, with round-to-nearest. The offset is then subtracted from the scaled value. The difference is clamped to the output width, and the sample leaves tagged with the channel it arrived on.

Both settings are read in the same cycle the input is valid. A sample already in the pipeline is therefore unaffected when a setting changes later. The stage has a fixed latency of two clock cycles and accepts a new sample in every cycle.

Top module: `shift_offset_stage`

## Requirements
- R1: While the synchronous reset `rst` is high, `outValid` is 0 in the cycle after each clock edge, whatever `inValid` is.
- R2: `outValid` is high exactly two clock cycles after a cycle in which `inValid` was high, and low two cycles after a cycle in which it was low. Back-to-back samples are accepted.
- R3: `outChan` carries the `inChan` value of the sample whose result is presented.
- R4: With a shift amount of 0, the scaled value equals the 32-bit signed input, so no rounding takes place.
- R5: With a shift amount s from 1 to 31, the scaled value is floor(x / 2^s + 1/2). The most significant shifted-out bit decides whether to round up, and that bit is then dropped. Exact halves round toward positive infinity.
- R6: The output is the scaled value minus the selected 24-bit two's-complement offset. The subtraction always comes after the shift.
- R7: Channel c uses shift bits `cfgShift[5c+4:5c]` and offset bits `cfgOffset[24c+23:24c]`. Both are taken from the cycle in which the sample's `inValid` is high, so later changes do not alter a sample already in the pipeline.
- R8: A difference above 8388607 produces 0x7FFFFF on `outData`.
- R9: A difference below -8388608 produces 0x800000 on `outData`.
- R10: `outData` and `outChan` keep their previous values in any cycle where `outValid` is low, even while the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample qualifier |
| inChan | input | 1 | Channel index of the input sample |
| inData | input | 32 | Signed filter result |
| cfgShift | input | 10 | Per-channel 5-bit shift amounts, channel 0 in the low bits |
| cfgOffset | input | 48 | Per-channel 24-bit signed offsets, channel 0 in the low bits |
| outValid | output | 1 | Output sample qualifier |
| outChan | output | 1 | Channel tag of the output sample |
| outData | output | 24 | Signed, saturated result |

## Verification
The result of a sample driven in cycle n appears on the outputs after the second rising edge that follows, in cycle n+2. The bench drives each sample just after a falling edge and computes its expected value at once, from the settings applied in that same cycle. It holds that expectation for exactly one step and compares it at the falling edge that follows the next rising edge. A cycle with `inValid` low therefore expects a low `outValid` one step later, along with the unchanged data and channel tag. Setting changes made while a sample is in flight are thus checked against the settings that sample was launched with.

// File: rtl/sos_pkg.sv
`timescale 1ns/1ps
package sos_pkg;

  // Load strobes sent from the control path to the datapath
  typedef struct packed {
    logic scaleLoad;   // capture the rounded, shifted value and the selected offset
    logic resultLoad;  // capture the saturated difference
  } sos_strobe_t;

endpackage

// File: rtl/sos_ctrl.sv
`timescale 1ns/1ps
module sos_ctrl
  import sos_pkg::*;
#(
  parameter int CH_W = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [CH_W-1:0] inChan,
  output sos_strobe_t     strobe,
  output logic            outValid,
  output logic [CH_W-1:0] outChan
);

  logic            midValid;
  logic [CH_W-1:0] midChan;

  always_ff @(posedge clk) begin
    if (rst) begin
      midValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      midValid <= inValid;
      outValid <= midValid;
    end
  end

  always_ff @(posedge clk) begin
    if (inValid)  midChan <= inChan;
    if (midValid) outChan <= midChan;
  end

  always_comb begin
    strobe.scaleLoad  = inValid;
    strobe.resultLoad = midValid;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> !outValid);

  p_stage_a_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> midValid);

  p_stage_b_r2: assert property (@(posedge clk) disable iff (rst)
    midValid |=> outValid);

  p_stage_c_r2: assert property (@(posedge clk) disable iff (rst)
    !midValid |=> !outValid);

  p_tag_r3: assert property (@(posedge clk) disable iff (rst)
    midValid |=> outChan == $past(midChan));

  p_tag_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !midValid |=> $stable(outChan));

endmodule

// File: rtl/sos_datapath.sv
`timescale 1ns/1ps
module sos_datapath
  import sos_pkg::*;
#(
  parameter int IN_W   = 32,
  parameter int OUT_W  = 24,
  parameter int OFS_W  = 24,
  parameter int NUM_CH = 2,
  parameter int SH_W   = 5,
  parameter int CH_W   = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  sos_strobe_t             strobe,
  input  logic [CH_W-1:0]         inChan,
  input  logic [IN_W-1:0]         inData,
  input  logic [NUM_CH*SH_W-1:0]  cfgShift,
  input  logic [NUM_CH*OFS_W-1:0] cfgOffset,
  output logic [OUT_W-1:0]        outData
);

  localparam int RW = IN_W + 1;   // scaled value width, covers the +1 carry
  localparam int DW = RW + 1;     // difference width

  localparam logic signed [DW-1:0] HI_LIM = {{(DW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [DW-1:0] LO_LIM = {{(DW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  // Per-channel setting unpack
  logic [SH_W-1:0]  shiftArr [NUM_CH];
  logic [OFS_W-1:0] offArr   [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign shiftArr[g] = cfgShift[g*SH_W +: SH_W];
    assign offArr[g]   = cfgOffset[g*OFS_W +: OFS_W];
  end

  logic [SH_W-1:0]  selShift;
  logic [OFS_W-1:0] selOff;
  assign selShift = shiftArr[inChan];
  assign selOff   = offArr[inChan];

  // Rounding shift: shift by s-1, add one at the lowest kept bit, drop that bit
  logic [SH_W-1:0]        shiftLess;
  logic signed [IN_W-1:0] preShift;
  logic signed [RW-1:0]   bumped;
  logic signed [RW-1:0]   scaled;

  always_comb begin
    shiftLess = selShift - 1'b1;
    preShift  = $signed(inData) >>> shiftLess;
    bumped    = $signed({preShift[IN_W-1], preShift}) + $signed(RW'(1));
    if (selShift == '0) scaled = $signed({inData[IN_W-1], inData});
    else                scaled = bumped >>> 1;
  end

  logic signed [RW-1:0] scaleReg;
  logic [OFS_W-1:0]     offReg;

  always_ff @(posedge clk) begin
    if (strobe.scaleLoad) begin
      scaleReg <= scaled;
      offReg   <= selOff;
    end
  end

  // Offset subtraction and saturation
  logic signed [DW-1:0] diff;
  logic [OUT_W-1:0]     satOut;

  always_comb begin
    diff = $signed({scaleReg[RW-1], scaleReg}) -
           $signed({{(DW-OFS_W){offReg[OFS_W-1]}}, offReg});
    if (diff > HI_LIM)      satOut = HI_LIM[OUT_W-1:0];
    else if (diff < LO_LIM) satOut = LO_LIM[OUT_W-1:0];
    else                    satOut = diff[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobe.resultLoad) outData <= satOut;
  end

  p_shift_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.scaleLoad && selShift == '0) |=>
      scaleReg == $signed({$past(inData[IN_W-1]), $past(inData)}));

  p_sat_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe.resultLoad && diff > HI_LIM) |=> outData == {1'b0, {(OUT_W-1){1'b1}}});

  p_sat_lo_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe.resultLoad && diff < LO_LIM) |=> outData == {1'b1, {(OUT_W-1){1'b0}}});

  p_offset_kept_r7: assert property (@(posedge clk) disable iff (rst)
    !strobe.scaleLoad |=> $stable(offReg));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !strobe.resultLoad |=> $stable(outData));

endmodule

// File: rtl/shift_offset_stage.sv
`timescale 1ns/1ps
module shift_offset_stage
  import sos_pkg::*;
#(
  parameter int IN_W   = 32,
  parameter int OUT_W  = 24,
  parameter int OFS_W  = 24,
  parameter int NUM_CH = 2,
  parameter int SH_W   = 5,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [CH_W-1:0]         inChan,
  input  logic [IN_W-1:0]         inData,
  input  logic [NUM_CH*SH_W-1:0]  cfgShift,
  input  logic [NUM_CH*OFS_W-1:0] cfgOffset,
  output logic                    outValid,
  output logic [CH_W-1:0]         outChan,
  output logic [OUT_W-1:0]        outData
);

  sos_strobe_t strobe;

  sos_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inChan   (inChan),
    .strobe   (strobe),
    .outValid (outValid),
    .outChan  (outChan)
  );

  sos_datapath #(
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .OFS_W  (OFS_W),
    .NUM_CH (NUM_CH),
    .SH_W   (SH_W),
    .CH_W   (CH_W)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .inChan    (inChan),
    .inData    (inData),
    .cfgShift  (cfgShift),
    .cfgOffset (cfgOffset),
    .outData   (outData)
  );

endmodule

// File: tb/shift_offset_stage_bench.sv
`timescale 1ns/1ps
module shift_offset_stage_bench;

  localparam int IN_W = 32, OUT_W = 24, OFS_W = 24, NUM_CH = 2, SH_W = 5;

  logic clk = 1'b0;
  logic rst;
  logic inValid;
  logic [0:0] inChan;
  logic [IN_W-1:0] inData;
  logic [NUM_CH*SH_W-1:0] cfgShift;
  logic [NUM_CH*OFS_W-1:0] cfgOffset;
  logic outValid;
  logic [0:0] outChan;
  logic [OUT_W-1:0] outData;

  always #2.5 clk = ~clk;

  shift_offset_stage u_shift_offset_stage (
    .clk(clk), .rst(rst), .inValid(inValid), .inChan(inChan), .inData(inData),
    .cfgShift(cfgShift), .cfgOffset(cfgOffset),
    .outValid(outValid), .outChan(outChan), .outData(outData)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int shv [NUM_CH];
  int ofv [NUM_CH];

  bit     pendV = 0;
  int     pendCh = 0;
  longint pendExp = 0;
  string  pendTag = "";
  bit     haveLast = 0;
  longint lastData = 0;
  int     lastChan = 0;

  function automatic longint model(longint x, int s, longint off);
    longint r, d;
    if (s == 0) r = x;
    else        r = (x + (64'sd1 <<< (s - 1))) >>> s;
    d = r - off;
    if (d > 64'sd8388607)  d = 64'sd8388607;
    if (d < -64'sd8388608) d = -64'sd8388608;
    return d;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(int ch, int sh, int off);
    shv[ch] = sh;
    ofv[ch] = off;
    cfgShift[ch*SH_W +: SH_W]    = sh[SH_W-1:0];
    cfgOffset[ch*OFS_W +: OFS_W] = off[OFS_W-1:0];
  endtask

  // Drive one cycle just after a falling edge; check the prior step's sample
  task automatic step(bit v, int ch, int x, string tag);
    longint e;
    longint act;
    inValid = v;
    inChan  = ch[0:0];
    inData  = x;
    e = model(longint'(x), shv[ch], longint'(ofv[ch]));
    @(posedge clk);
    @(negedge clk);
    act = longint'($signed(outData));
    chk(outValid == pendV, "R2", longint'(outValid), longint'(pendV));
    if (pendV) begin
      chk(act == pendExp, pendTag, act, pendExp);
      chk(int'(outChan) == pendCh, "R3", longint'(outChan), longint'(pendCh));
    end else if (haveLast) begin
      chk(act == lastData, "R10 data", act, lastData);
      chk(int'(outChan) == lastChan, "R10 chan", longint'(outChan), longint'(lastChan));
    end
    if (outValid) haveLast = 1;
    lastData = act;
    lastChan = int'(outChan);
    pendV = v; pendCh = ch; pendExp = e; pendTag = tag;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int vals [10];
    rst = 1'b1;
    inValid = 1'b0;
    inChan = '0;
    inData = '0;
    cfgShift = '0;
    cfgOffset = '0;
    for (int c = 0; c < NUM_CH; c++) setCfg(c, 0, 0);

    // R1: outValid stays low under reset even with inValid high
    @(negedge clk);
    inValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(outValid == 1'b0, "R1", longint'(outValid), 0);
    end
    inValid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R4: shift of zero passes the input through
    setCfg(0, 0, 0);
    step(1, 0, 12345, "R4");
    step(1, 0, -8388608, "R4");
    step(1, 0, 8388607, "R4");
    step(1, 0, -1, "R4");
    step(0, 0, 77, "R10");

    // R6: shift first, then subtract (5>>2 rounds to 1, minus 2 is -1)
    setCfg(1, 2, 2);
    step(1, 1, 5, "R6");
    step(1, 1, -7, "R6");

    // R8 / R9: saturation at both ends
    setCfg(0, 0, -8388608);
    step(1, 0, 8388607, "R8");
    step(1, 0, 32'h7FFFFFFF, "R8");
    setCfg(1, 0, 8388607);
    step(1, 1, -2, "R9");
    step(1, 1, 32'h80000000, "R9");
    setCfg(1, 31, 8388607);
    step(1, 1, 32'h80000000, "R9");

    // R5 / R7: sweep every shift on both channels, interleaved
    for (int s = 0; s < 32; s++) begin
      longint h = (s == 0) ? 64'sd0 : (64'sd1 <<< (s - 1));
      setCfg(0, s, 1000);
      setCfg(1, 31 - s, -777);
      vals[0] = int'(h);
      vals[1] = int'(-h);
      vals[2] = int'(h - 1);
      vals[3] = int'(-h - 1);
      vals[4] = 32'h7FFFFFFF;
      vals[5] = 32'h80000000;
      vals[6] = 32'h12345678;
      vals[7] = -32'h12345679;
      vals[8] = int'(3 * (64'sd1 <<< s) + h);
      vals[9] = (s % 2 == 0) ? 1 : -1;
      for (int k = 0; k < 10; k++) begin
        step(1, 0, vals[k], "R5");
        step(1, 1, vals[k], "R7");
        if (k == 4) step(0, 1, vals[k] ^ 32'h5A5A5A5A, "R10");
      end
    end

    // R7: setting change after launch leaves the in-flight sample alone
    setCfg(0, 4, 100);
    step(1, 0, 1000, "R7");
    setCfg(0, 9, -5000);
    step(0, 0, 2222, "R10");
    step(1, 0, 1000, "R7");
    setCfg(0, 1, 0);
    step(1, 0, 3, "R5");
    setCfg(0, 0, 0);

    // R10: idle cycles with toggling inputs
    for (int i = 0; i < 6; i++) step(0, i % 2, 32'h0F0F0F0F * i, "R10");

    finish_run();
  end

endmodule